// File: doc/BRIEF.md
# Timer interrupt flag controller

This block sits beside a general-purpose timer and merges its event pulses into one interrupt request line. There are six event sources: an update event, an external trigger, and a capture/compare event on each of four channels. Each source has a sticky status flag. A mask chooses which flags may raise the request. A global enable gates the request, and it has separate set and clear addresses.

When a capture/compare event arrives on a channel whose flag is still set, the block records an overrun in a per-channel missed register. If a channel is in capture mode, a read of its capture value also clears that channel's flag; the capture data registers are outside the block and only their read strobes come in.

Software reaches the block over a simple register bus. Writes take effect at the clock edge and reads are combinational. Register map: 0 = status (write 1 to clear), 1 = mask (read/write), 2 = missed (write 1 to clear), 3 = enable set, 4 = enable clear. Addresses 3 and 4 both read back the enable in bit 0.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: Each event sets its own status flag at the next clock edge. The status bits are: bit 0 update, bit 1 trigger, bits 2 to 5 for channels 0 to 3.
- R2: Writing 1 to a status bit clears that flag. Writing 0 leaves the flag unchanged.
- R3: A capture read strobe on a channel whose mode input is 1 (capture) clears that channel's flag. The same strobe has no effect when the mode input is 0 (compare).
- R4: A flag can drive the interrupt only while its bit in the mask register (address 1, same bit layout as status) is 1.
- R5: A capture/compare event on a channel whose flag is already set sets that channel's missed bit. Missed bit n belongs to channel n.
- R6: Writing 1 to a missed bit clears it. Writing 0 leaves it unchanged.
- R7: With the gated-mode input at 0, only a rising edge of the trigger input sets the trigger flag.
- R8: With the gated-mode input at 1, both rising and falling edges of the trigger input set the trigger flag.
- R9: Writing 1 to bit 0 at address 3 sets the global enable. Writing 1 to bit 0 at address 4 clears it. The interrupt is high only while the enable is set and at least one flag is both set and unmasked.
- R10: If an event and a clear (a bus write or a capture read) hit the same flag in the same cycle, the flag stays set.
- R11: After reset, all flags, mask bits, missed bits and the enable are 0, and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_update | input | 1 | Update event pulse |
| trig_in | input | 1 | External trigger level |
| trig_gated | input | 1 | 1 = count both trigger edges |
| evt_cc | input | NCH | Capture/compare event pulses |
| cc_capture_mode | input | NCH | Per channel: 1 = capture, 0 = compare |
| cap_rd | input | NCH | Capture value read strobes |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A flag that fails to stick, or that clears on the wrong write, shows up on the status read in the cycle after the stimulus. If the mask or enable are at fault, the error appears on the interrupt line one edge after the offending write. Wrong missed-register logic is visible only after a second event on the same channel, so the bench repeats events deliberately. Errors in trigger edge detection show only when the trigger falls, so the bench drives falling edges in both trigger modes.

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           evt_update,
  input  logic           trig_in,
  input  logic           trig_gated,
  input  logic [NCH-1:0] evt_cc,
  input  logic [NCH-1:0] cc_capture_mode,
  input  logic [NCH-1:0] cap_rd,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           irq
);
  localparam int NF = NCH + 2;
  localparam logic [AW-1:0] A_STAT  = AW'(0);
  localparam logic [AW-1:0] A_MASK  = AW'(1);
  localparam logic [AW-1:0] A_MISS  = AW'(2);
  localparam logic [AW-1:0] A_ENSET = AW'(3);
  localparam logic [AW-1:0] A_ENCLR = AW'(4);

  logic [NF-1:0]  flag_q, mask_q;
  logic [NCH-1:0] miss_q;
  logic           en_q, trig_q;

  wire wr_stat  = bus_wr && (bus_addr == A_STAT);
  wire wr_mask  = bus_wr && (bus_addr == A_MASK);
  wire wr_miss  = bus_wr && (bus_addr == A_MISS);
  wire wr_enset = bus_wr && (bus_addr == A_ENSET) && bus_wdata[0];
  wire wr_enclr = bus_wr && (bus_addr == A_ENCLR) && bus_wdata[0];

  wire trig_evt = trig_gated ? (trig_in ^ trig_q) : (trig_in & ~trig_q);

  wire [NF-1:0]  evt_vec  = {evt_cc, trig_evt, evt_update};
  wire [NF-1:0]  rd_clr   = {cap_rd & cc_capture_mode, 2'b00};
  wire [NF-1:0]  stat_clr = wr_stat ? bus_wdata[NF-1:0] : '0;
  wire [NCH-1:0] miss_clr = wr_miss ? bus_wdata[NCH-1:0] : '0;
  wire [NCH-1:0] miss_set = evt_cc & flag_q[NF-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
      miss_q <= '0;
      en_q   <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig_in;
      flag_q <= (flag_q & ~(stat_clr | rd_clr)) | evt_vec;
      miss_q <= (miss_q & ~miss_clr) | miss_set;
      if (wr_mask) mask_q <= bus_wdata[NF-1:0];
      if (wr_enset)      en_q <= 1'b1;
      else if (wr_enclr) en_q <= 1'b0;
    end
  end

  assign irq = en_q && |(flag_q & mask_q);

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = DW'(flag_q);
      A_MASK:  bus_rdata = DW'(mask_q);
      A_MISS:  bus_rdata = DW'(miss_q);
      A_ENSET,
      A_ENCLR: bus_rdata = DW'(en_q);
      default: bus_rdata = '0;
    endcase
  end

  a_r1_update_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_update |=> flag_q[0]);
  a_r2_update_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && !evt_update) |=> !flag_q[0]);
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & mask_q) == '0) |-> !irq);
  a_r9_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enclr |=> !irq);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r1_cc_sets: assert property (@(posedge clk) disable iff (!rst_n)
      evt_cc[c] |=> flag_q[c+2]);
    a_r3_cap_read: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_rd[c] && cc_capture_mode[c] && !evt_cc[c]) |=> !flag_q[c+2]);
    a_r5_missed: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_cc[c] && flag_q[c+2]) |=> miss_q[c]);
    a_r6_miss_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_miss && bus_wdata[c] && !(evt_cc[c] && flag_q[c+2])) |=> !miss_q[c]);
  end
endmodule

// File: tb/tmr_irq_ctrl_bench.sv
module tmr_irq_ctrl_bench;
  localparam int NCH = 4, DW = 32, AW = 3;
  logic clk = 0, rst_n = 0;
  logic evt_update = 0, trig_in = 0, trig_gated = 0, bus_wr = 0;
  logic [NCH-1:0] evt_cc = 0, cc_capture_mode = 0, cap_rd = 0;
  logic [AW-1:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0, bus_rdata;
  logic irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  tmr_irq_ctrl #(.NCH(NCH), .DW(DW), .AW(AW)) u_tmr_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_update(evt_update), .trig_in(trig_in),
    .trig_gated(trig_gated), .evt_cc(evt_cc), .cc_capture_mode(cc_capture_mode),
    .cap_rd(cap_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse_upd();
    @(negedge clk); evt_update = 1; @(negedge clk); evt_update = 0;
  endtask

  task automatic pulse_cc(logic [NCH-1:0] m);
    @(negedge clk); evt_cc = m; @(negedge clk); evt_cc = 0;
  endtask

  task automatic pulse_rd(logic [NCH-1:0] m);
    @(negedge clk); cap_rd = m; @(negedge clk); cap_rd = 0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(AW'(a), v); check("R11 reset register", v, 0);
    end
    check("R11 reset irq", DW'(irq), 0);
  endtask

  task automatic t_events();
    logic [DW-1:0] v;
    pulse_upd(); rd(0, v); check("R1 update flag", v, 32'h01);
    pulse_cc(4'b0100); rd(0, v); check("R1 channel 2 flag", v, 32'h11);
    check("R4 irq with mask 0", DW'(irq), 0);
  endtask

  task automatic t_w1c();
    logic [DW-1:0] v;
    wr(0, 0); rd(0, v); check("R2 write 0 keeps", v, 32'h11);
    wr(0, 32'h01); rd(0, v); check("R2 clear update", v, 32'h10);
    wr(0, 32'h10); rd(0, v); check("R2 clear channel", v, 0);
  endtask

  task automatic t_mask_irq();
    logic [DW-1:0] v;
    pulse_upd(); wr(3, 1);
    check("R4 unmasked flag absent", DW'(irq), 0);
    wr(1, 32'h02); check("R4 other bit masked", DW'(irq), 0);
    wr(1, 32'h01); check("R4 irq when unmasked", DW'(irq), 1);
    wr(4, 1); check("R9 enable clear drops irq", DW'(irq), 0);
    rd(3, v); check("R9 enable reads 0", v, 0);
    wr(3, 1); check("R9 enable set raises irq", DW'(irq), 1);
    wr(0, 32'h01); check("R2 clear drops irq", DW'(irq), 0);
    wr(1, 0); wr(4, 1);
  endtask

  task automatic t_capread();
    logic [DW-1:0] v;
    cc_capture_mode = 4'b0010;
    pulse_cc(4'b0011); rd(0, v); check("R1 channels 0,1", v, 32'h0C);
    pulse_rd(4'b0010); rd(0, v); check("R3 capture read clears", v, 32'h04);
    pulse_rd(4'b0001); rd(0, v); check("R3 compare read ignored", v, 32'h04);
    wr(0, 32'h3F); cc_capture_mode = 0;
  endtask

  task automatic t_missed();
    logic [DW-1:0] v;
    pulse_cc(4'b1000); rd(2, v); check("R5 first event no miss", v, 0);
    pulse_cc(4'b1001); rd(2, v); check("R5 second event missed", v, 32'h8);
    wr(2, 0); rd(2, v); check("R6 write 0 keeps miss", v, 32'h8);
    wr(2, 32'h8); rd(2, v); check("R6 miss cleared", v, 0);
    wr(0, 32'h3F);
  endtask

  task automatic t_trig();
    logic [DW-1:0] v;
    @(negedge clk); trig_in = 1; rd(0, v); check("R7 rising sets", v, 32'h02);
    wr(0, 32'h02);
    @(negedge clk); trig_in = 0; rd(0, v); check("R7 falling ignored", v, 0);
    trig_gated = 1;
    @(negedge clk); trig_in = 1; rd(0, v); check("R8 gated rising", v, 32'h02);
    wr(0, 32'h02);
    @(negedge clk); trig_in = 0; rd(0, v); check("R8 gated falling", v, 32'h02);
    wr(0, 32'h02); trig_gated = 0;
  endtask

  task automatic t_race();
    logic [DW-1:0] v;
    pulse_upd();
    @(negedge clk); bus_wr = 1; bus_addr = 0; bus_wdata = 32'h01; evt_update = 1;
    @(negedge clk); bus_wr = 0; bus_wdata = 0; evt_update = 0;
    rd(0, v); check("R10 event beats write clear", v, 32'h01);
    cc_capture_mode = 4'b0001;
    @(negedge clk); cap_rd = 4'b0001; evt_cc = 4'b0001;
    @(negedge clk); cap_rd = 0; evt_cc = 0;
    rd(0, v); check("R10 event beats read clear", v, 32'h05);
    cc_capture_mode = 0; wr(0, 32'h3F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_events(); t_w1c(); t_mask_irq();
    t_capread(); t_missed(); t_trig(); t_race();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule